// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Incremental Squash

This block holds in-flight instructions for a core that runs several hardware threads. Each thread owns its own circular in-order queue. An entry stores a sequence number, a program counter, a ready flag and a squashed flag. Dispatch appends an entry to the tail of the selected thread's queue. A per-thread completion port sets the ready flag of the entry whose sequence number matches. A single retire port removes a thread's oldest entry once that entry is ready.

A squash request names a thread and a sequence number. The block does not delete the younger entries at once. Starting in the cycle after the request, a walker moves from that thread's youngest entry toward its head and handles a bounded number of entries per cycle. Each entry it passes is flagged squashed and ready, so the entry leaves through normal retirement. A new request to a thread that is still squashing restarts the walk from that thread's current youngest entry.

For commit logic the block reports per-thread head status and a can-commit flag. For squash and recovery logic it reports the globally oldest and youngest entries among the active threads.

Top module: `mt_rob`

## Requirements
- R1: A dispatch for thread t appends {sequence, pc} at t's tail. That thread's head outputs present its oldest entry, with the sequence number and pc it was dispatched with.
- R2: rob_full_o is high when rob_count_o equals CAPACITY. A dispatch in that state is dropped: the count, the queues and every head and youngest output stay as they were.
- R3: A completion on thread t sets the ready flag of the occupied entry of t whose sequence number equals the completion value. The change is visible after the next clock edge.
- R4: A retire on thread t removes t's head only if the head is ready. A retire on a non-ready head is ignored. rob_count_o is the number of held entries.
- R5: can_commit_o is high exactly when some thread that is active (thread_active_i bit set) and non-empty has a ready head. An inactive thread is ignored.
- R6: The oldest_* outputs report the head with the lowest sequence number among active, non-empty threads. oldest_valid_o is low when there is no such head.
- R7: The youngest_* outputs report the tail entry with the highest sequence number among active, non-empty threads. Squashed entries still count.
- R8: A squash request on a thread that holds entries raises squashing_o for that thread after the request edge. From the next edge on, up to SQ_WIDTH entries per cycle, youngest first, are set squashed and ready.
- R9: The walk ends in the cycle it marks the thread's head, or in the cycle where the next unvisited entry has a sequence number at or below the squash number. squashing_o falls after that edge.
- R10: A squash request is ignored when the whole buffer is empty, or when the named thread is empty.
- R11: While a thread is squashing, and in the cycle of its squash request, a retire on that thread is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active_i | input | THREADS | Active-thread mask for head, youngest and can-commit selection |
| disp_valid_i | input | 1 | Dispatch request |
| disp_tid_i | input | TID_W | Dispatch thread |
| disp_seq_i | input | SEQ_W | Dispatch sequence number |
| disp_pc_i | input | PC_W | Dispatch program counter |
| rob_full_o | output | 1 | Buffer holds CAPACITY entries |
| cmpl_valid_i | input | THREADS | Per-thread completion strobe |
| cmpl_seq_i | input | THREADS*SEQ_W | Per-thread completed sequence number |
| retire_valid_i | input | 1 | Retire request |
| retire_tid_i | input | TID_W | Retire thread |
| sq_valid_i | input | 1 | Squash request |
| sq_tid_i | input | TID_W | Squash thread |
| sq_seq_i | input | SEQ_W | Squash sequence number; younger entries are squashed |
| head_valid_o | output | THREADS | Thread holds at least one entry |
| head_ready_o | output | THREADS | Thread head is ready |
| head_squashed_o | output | THREADS | Thread head is squashed |
| head_seq_o | output | THREADS*SEQ_W | Thread head sequence numbers |
| head_pc_o | output | THREADS*PC_W | Thread head program counters |
| squashing_o | output | THREADS | Squash walk in progress |
| can_commit_o | output | 1 | Some active head is ready |
| rob_count_o | output | CNT_W | Entries held |
| oldest_valid_o | output | 1 | Global oldest head exists |
| oldest_tid_o | output | TID_W | Thread of global oldest head |
| oldest_seq_o | output | SEQ_W | Sequence number of global oldest head |
| youngest_valid_o | output | 1 | Global youngest entry exists |
| youngest_tid_o | output | TID_W | Thread of global youngest entry |
| youngest_seq_o | output | SEQ_W | Sequence number of global youngest entry |

## Verification
A walker pointer that goes astray shows up one retirement later: a head that should be squashed comes out with head_squashed_o low, or can_commit_o stays low. A wrong stop decision shows up at once as squashing_o falling one cycle early or late. Ready flags or counters that drift show on head_ready_o and rob_count_o at the next edge. A wrong age comparison shows directly on the oldest and youngest outputs in the same cycle, because those outputs are combinational over the queue heads and tails.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {PICK_OLDEST, PICK_YOUNGEST} age_pick_e;

  function automatic int ring_next(int p, int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int ring_prev(int p, int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  function automatic int ring_dist(int from, int to, int depth);
    return (to >= from) ? to - from : to + depth - from;
  endfunction
endpackage

// File: rtl/rob_thread_queue.sv
module rob_thread_queue
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int SQ_WIDTH = 2,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic [PC_W-1:0]  push_pc_i,
  input  logic             pop_req_i,
  input  logic             cmpl_i,
  input  logic [SEQ_W-1:0] cmpl_seq_i,
  input  logic             sq_req_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic             empty_o,
  output logic             head_ready_o,
  output logic             head_squashed_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic [PC_W-1:0]  head_pc_o,
  output logic [SEQ_W-1:0] tail_seq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             squashing_o,
  output logic             pop_fire_o
);
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [DEPTH-1:0] rdy_q, sqd_q;
  logic [IDX_W-1:0] head_q, tail_q, walk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sq_busy_q;
  logic [SEQ_W-1:0] sq_num_q;

  // named internal events
  logic             sq_start, walk_en, w_done, pop_fire;
  logic [IDX_W-1:0] w_ptr;
  logic [DEPTH-1:0] mark, cmpl_hit, push_mask;

  function automatic logic [IDX_W-1:0] nxt(logic [IDX_W-1:0] p);
    return IDX_W'(ring_next(int'(p), DEPTH));
  endfunction

  function automatic logic [IDX_W-1:0] prv(logic [IDX_W-1:0] p);
    return IDX_W'(ring_prev(int'(p), DEPTH));
  endfunction

  assign sq_start  = sq_req_i && (cnt_q != '0);
  assign walk_en   = sq_busy_q && !sq_start;
  assign pop_fire  = pop_req_i && (cnt_q != '0) && rdy_q[head_q] && !sq_busy_q && !sq_start;
  assign push_mask = push_i ? (DEPTH'(1) << tail_q) : '0;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cmpl_hit[i] = cmpl_i && (ring_dist(int'(head_q), i, DEPTH) < int'(cnt_q))
                    && (seq_q[i] == cmpl_seq_i);
    end
  end

  // squash walker: youngest toward head, SQ_WIDTH entries at most
  always_comb begin
    logic live;
    live   = walk_en;
    w_ptr  = walk_q;
    w_done = 1'b0;
    mark   = '0;
    for (int i = 0; i < SQ_WIDTH; i++) begin
      if (live) begin
        if (seq_q[w_ptr] > sq_num_q) begin
          mark[w_ptr] = 1'b1;
          if (w_ptr == head_q) begin
            w_done = 1'b1;
            live   = 1'b0;
          end else begin
            w_ptr = prv(w_ptr);
          end
        end else begin
          w_done = 1'b1;
          live   = 1'b0;
        end
      end
    end
    if (live && (seq_q[w_ptr] <= sq_num_q)) w_done = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
      walk_q    <= '0;
      sq_busy_q <= 1'b0;
      sq_num_q  <= '0;
      rdy_q     <= '0;
      sqd_q     <= '0;
    end else begin
      if (push_i)   tail_q <= nxt(tail_q);
      if (pop_fire) head_q <= nxt(head_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_fire);
      if (sq_start) begin
        sq_busy_q <= 1'b1;
        sq_num_q  <= sq_seq_i;
        walk_q    <= prv(tail_q);
      end else if (walk_en) begin
        walk_q <= w_ptr;
        if (w_done) sq_busy_q <= 1'b0;
      end
      rdy_q <= (rdy_q | mark | cmpl_hit) & ~push_mask;
      sqd_q <= (sqd_q | mark) & ~push_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      seq_q[tail_q] <= push_seq_i;
      pc_q[tail_q]  <= push_pc_i;
    end
  end

  assign empty_o         = (cnt_q == '0);
  assign head_ready_o    = !empty_o && rdy_q[head_q];
  assign head_squashed_o = !empty_o && sqd_q[head_q];
  assign head_seq_o      = seq_q[head_q];
  assign head_pc_o       = pc_q[head_q];
  assign tail_seq_o      = seq_q[prv(tail_q)];
  assign cnt_o           = cnt_q;
  assign squashing_o     = sq_busy_q;
  assign pop_fire_o      = pop_fire;

  assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));
  assert_pop_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> head_ready_o);
  assert_no_pop_squash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sq_busy_q |-> !pop_fire);
  assert_squash_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    head_squashed_o |-> head_ready_o);
  assert_walk_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_en && w_done) |=> !sq_busy_q);
endmodule

// File: rtl/rob_age_select.sv
module rob_age_select
  import rob_pkg::*;
#(
  parameter int        THREADS = 2,
  parameter int        SEQ_W   = 16,
  parameter age_pick_e PICK    = PICK_OLDEST,
  localparam int       TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic [THREADS-1:0]       valid_i,
  input  logic [THREADS*SEQ_W-1:0] seq_i,
  output logic                     valid_o,
  output logic [TID_W-1:0]         tid_o,
  output logic [SEQ_W-1:0]         seq_o
);
  function automatic logic beats(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    return (PICK == PICK_OLDEST) ? (a < b) : (a > b);
  endfunction

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    seq_o   = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (valid_i[t] && (!valid_o || beats(seq_i[t*SEQ_W +: SEQ_W], seq_o))) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(t);
        seq_o   = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/mt_rob.sv
module mt_rob
  import rob_pkg::*;
#(
  parameter int  THREADS  = 2,
  parameter int  CAPACITY = 8,
  parameter int  SEQ_W    = 16,
  parameter int  PC_W     = 32,
  parameter int  SQ_WIDTH = 2,
  localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W    = $clog2(CAPACITY + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [THREADS-1:0]       thread_active_i,
  input  logic                     disp_valid_i,
  input  logic [TID_W-1:0]         disp_tid_i,
  input  logic [SEQ_W-1:0]         disp_seq_i,
  input  logic [PC_W-1:0]          disp_pc_i,
  output logic                     rob_full_o,
  input  logic [THREADS-1:0]       cmpl_valid_i,
  input  logic [THREADS*SEQ_W-1:0] cmpl_seq_i,
  input  logic                     retire_valid_i,
  input  logic [TID_W-1:0]         retire_tid_i,
  input  logic                     sq_valid_i,
  input  logic [TID_W-1:0]         sq_tid_i,
  input  logic [SEQ_W-1:0]         sq_seq_i,
  output logic [THREADS-1:0]       head_valid_o,
  output logic [THREADS-1:0]       head_ready_o,
  output logic [THREADS-1:0]       head_squashed_o,
  output logic [THREADS*SEQ_W-1:0] head_seq_o,
  output logic [THREADS*PC_W-1:0]  head_pc_o,
  output logic [THREADS-1:0]       squashing_o,
  output logic                     can_commit_o,
  output logic [CNT_W-1:0]         rob_count_o,
  output logic                     oldest_valid_o,
  output logic [TID_W-1:0]         oldest_tid_o,
  output logic [SEQ_W-1:0]         oldest_seq_o,
  output logic                     youngest_valid_o,
  output logic [TID_W-1:0]         youngest_tid_o,
  output logic [SEQ_W-1:0]         youngest_seq_o
);
  localparam int Q_CNT_W = $clog2(CAPACITY + 1);

  logic [CNT_W-1:0]         count_q, count_sum;
  logic                     disp_ok, sq_ok;
  logic [THREADS-1:0]       empty, pop_fire;
  logic [THREADS*SEQ_W-1:0] tail_seq;
  logic [Q_CNT_W-1:0]       tcnt [THREADS];

  assign rob_full_o = (count_q == CNT_W'(CAPACITY));
  assign disp_ok    = disp_valid_i && !rob_full_o;
  assign sq_ok      = sq_valid_i && (count_q != '0);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    rob_thread_queue #(
      .DEPTH(CAPACITY), .SEQ_W(SEQ_W), .PC_W(PC_W), .SQ_WIDTH(SQ_WIDTH)
    ) u_q (
      .clk             (clk),
      .rst_n           (rst_n),
      .push_i          (disp_ok && (disp_tid_i == TID_W'(t))),
      .push_seq_i      (disp_seq_i),
      .push_pc_i       (disp_pc_i),
      .pop_req_i       (retire_valid_i && (retire_tid_i == TID_W'(t))),
      .cmpl_i          (cmpl_valid_i[t]),
      .cmpl_seq_i      (cmpl_seq_i[t*SEQ_W +: SEQ_W]),
      .sq_req_i        (sq_ok && (sq_tid_i == TID_W'(t))),
      .sq_seq_i        (sq_seq_i),
      .empty_o         (empty[t]),
      .head_ready_o    (head_ready_o[t]),
      .head_squashed_o (head_squashed_o[t]),
      .head_seq_o      (head_seq_o[t*SEQ_W +: SEQ_W]),
      .head_pc_o       (head_pc_o[t*PC_W +: PC_W]),
      .tail_seq_o      (tail_seq[t*SEQ_W +: SEQ_W]),
      .cnt_o           (tcnt[t]),
      .squashing_o     (squashing_o[t]),
      .pop_fire_o      (pop_fire[t])
    );
  end

  assign head_valid_o = ~empty;
  assign can_commit_o = |(head_ready_o & thread_active_i);

  rob_age_select #(.THREADS(THREADS), .SEQ_W(SEQ_W), .PICK(PICK_OLDEST)) u_oldest (
    .valid_i (thread_active_i & ~empty),
    .seq_i   (head_seq_o),
    .valid_o (oldest_valid_o),
    .tid_o   (oldest_tid_o),
    .seq_o   (oldest_seq_o)
  );

  rob_age_select #(.THREADS(THREADS), .SEQ_W(SEQ_W), .PICK(PICK_YOUNGEST)) u_youngest (
    .valid_i (thread_active_i & ~empty),
    .seq_i   (tail_seq),
    .valid_o (youngest_valid_o),
    .tid_o   (youngest_tid_o),
    .seq_o   (youngest_seq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_q + CNT_W'(disp_ok) - CNT_W'($countones(pop_fire));
  end
  assign rob_count_o = count_q;

  always_comb begin
    count_sum = '0;
    for (int t = 0; t < THREADS; t++) count_sum = count_sum + CNT_W'(tcnt[t]);
  end

  assert_count_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q == count_sum);
  assert_one_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_fire));
  assert_oldest_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_valid_o |-> (count_q != '0));
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_full_o && (pop_fire == '0)) |=> rob_full_o);
endmodule

// File: tb/mt_rob_tb_top.sv
module mt_rob_tb_top;
  localparam int T = 2, CAP = 8, SW = 16, PW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [T-1:0]    active = 2'b11;
  logic            disp_valid = 0, retire_valid = 0, sq_valid = 0;
  logic            disp_tid = 0, retire_tid = 0, sq_tid = 0;
  logic [SW-1:0]   disp_seq = 0, sq_seq = 0;
  logic [PW-1:0]   disp_pc = 0;
  logic [T-1:0]    cmpl_valid = 0;
  logic [T*SW-1:0] cmpl_seq = 0;
  logic            full, can_commit, ov, yv;
  logic [T-1:0]    hv, hr, hs, sqg;
  logic [T*SW-1:0] hseq;
  logic [T*PW-1:0] hpc;
  logic [3:0]      cnt;
  logic            otid, ytid;
  logic [SW-1:0]   oseq, yseq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mt_rob #(.THREADS(T), .CAPACITY(CAP), .SEQ_W(SW), .PC_W(PW), .SQ_WIDTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .thread_active_i(active),
    .disp_valid_i(disp_valid), .disp_tid_i(disp_tid), .disp_seq_i(disp_seq), .disp_pc_i(disp_pc),
    .rob_full_o(full), .cmpl_valid_i(cmpl_valid), .cmpl_seq_i(cmpl_seq),
    .retire_valid_i(retire_valid), .retire_tid_i(retire_tid),
    .sq_valid_i(sq_valid), .sq_tid_i(sq_tid), .sq_seq_i(sq_seq),
    .head_valid_o(hv), .head_ready_o(hr), .head_squashed_o(hs), .head_seq_o(hseq),
    .head_pc_o(hpc), .squashing_o(sqg), .can_commit_o(can_commit), .rob_count_o(cnt),
    .oldest_valid_o(ov), .oldest_tid_o(otid), .oldest_seq_o(oseq),
    .youngest_valid_o(yv), .youngest_tid_o(ytid), .youngest_seq_o(yseq)
  );

  // op: 0 dispatch, 1 complete, 2 retire, 3 squash, 4 idle
  typedef struct packed {
    logic [2:0]  op;
    logic        tid;
    logic [15:0] seq;
    logic [3:0]  cnt;
    logic        cc;
    logic        ov;
    logic [15:0] oseq;
    logic [15:0] yseq;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 1'b0, 16'd10, 4'd1, 1'b0, 1'b1, 16'd10, 16'd10},
    '{3'd0, 1'b1, 16'd11, 4'd2, 1'b0, 1'b1, 16'd10, 16'd11},
    '{3'd0, 1'b0, 16'd12, 4'd3, 1'b0, 1'b1, 16'd10, 16'd12},
    '{3'd0, 1'b1, 16'd13, 4'd4, 1'b0, 1'b1, 16'd10, 16'd13},
    '{3'd1, 1'b1, 16'd11, 4'd4, 1'b1, 1'b1, 16'd10, 16'd13},
    '{3'd2, 1'b1, 16'd0,  4'd3, 1'b0, 1'b1, 16'd10, 16'd13},
    '{3'd1, 1'b0, 16'd12, 4'd3, 1'b0, 1'b1, 16'd10, 16'd13},
    '{3'd1, 1'b0, 16'd10, 4'd3, 1'b1, 1'b1, 16'd10, 16'd13},
    '{3'd2, 1'b0, 16'd0,  4'd2, 1'b1, 1'b1, 16'd12, 16'd13},
    '{3'd2, 1'b0, 16'd0,  4'd1, 1'b0, 1'b1, 16'd13, 16'd13}
  };

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int tid, input int seq);
    @(negedge clk);
    case (op)
      0: begin disp_valid = 1; disp_tid = tid[0]; disp_seq = SW'(seq); disp_pc = PW'(seq * 4); end
      1: begin cmpl_valid[tid] = 1'b1; cmpl_seq[tid*SW +: SW] = SW'(seq); end
      2: begin retire_valid = 1; retire_tid = tid[0]; end
      3: begin sq_valid = 1; sq_tid = tid[0]; sq_seq = SW'(seq); end
      default: ;
    endcase
    @(posedge clk);
    #1;
    disp_valid = 0; retire_valid = 0; sq_valid = 0; cmpl_valid = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    chk("R4 reset count", cnt, 0);
    chk("R5 reset can_commit", can_commit, 0);
    chk("R6 reset oldest_valid", ov, 0);
    chk("R8 reset squashing", sqg, 0);
    chk("R2 reset full", full, 0);

    // vector table: dispatch, completion, retirement, selection
    for (int i = 0; i < 10; i++) begin
      do_op(int'(VEC[i].op), int'(VEC[i].tid), int'(VEC[i].seq));
      chk($sformatf("R4 row%0d count", i), cnt, VEC[i].cnt);
      chk($sformatf("R5 row%0d can_commit", i), can_commit, VEC[i].cc);
      chk($sformatf("R6 row%0d oldest_valid", i), ov, VEC[i].ov);
      chk($sformatf("R6 row%0d oldest_seq", i), oseq, VEC[i].oseq);
      chk($sformatf("R7 row%0d youngest_seq", i), yseq, VEC[i].yseq);
    end

    // incremental squash walk on thread 1 (holds 13)
    for (int s = 14; s <= 18; s++) do_op(0, 1, s);
    chk("R7 youngest seq 18", yseq, 18);
    chk("R7 youngest tid 1", ytid, 1);
    do_op(3, 1, 14);
    chk("R8 squashing after request", sqg, 2'b10);
    do_op(4, 0, 0);
    chk("R9 walk continues after first slice", sqg, 2'b10);
    do_op(4, 0, 0);
    chk("R9 walk done at seq<=squash", sqg, 2'b00);
    chk("R8 older head not squashed", hs[1], 0);
    do_op(1, 1, 13); do_op(2, 1, 0);
    do_op(1, 1, 14); do_op(2, 1, 0);
    chk("R4 count after drains", cnt, 4);
    chk("R8 squashed head flag", hs[1], 1);
    chk("R8 squashed head ready", hr[1], 1);
    chk("R1 head seq 15", hseq[SW +: SW], 15);
    for (int k = 0; k < 4; k++) do_op(2, 1, 0);
    chk("R8 squashed entries drain", cnt, 0);
    chk("R6 empty oldest invalid", ov, 0);

    // retire blocked while squashing
    do_op(0, 0, 20); do_op(0, 0, 21); do_op(1, 0, 20);
    do_op(3, 0, 5);
    chk("R8 thread0 squashing", sqg, 2'b01);
    do_op(2, 0, 0);
    chk("R11 retire ignored while squashing", cnt, 2);
    chk("R9 walk reached head", sqg, 2'b00);
    do_op(2, 0, 0); do_op(2, 0, 0);
    chk("R11 retire after walk", cnt, 0);

    // squash on empty buffer
    do_op(3, 0, 0);
    chk("R10 empty squash ignored", sqg, 2'b00);

    // fill
    for (int s = 40; s <= 47; s++) do_op(0, 0, s);
    chk("R2 full flag", full, 1);
    chk("R1 head seq 40", hseq[0 +: SW], 40);
    chk("R1 head pc", hpc[0 +: PW], 160);
    do_op(0, 1, 50);
    chk("R2 dispatch when full count", cnt, 8);
    chk("R2 dispatch when full t1 empty", hv[1], 0);
    chk("R7 youngest unchanged", yseq, 47);
    do_op(2, 0, 0);
    chk("R4 non-ready retire ignored", cnt, 8);
    do_op(1, 0, 40);
    chk("R3 completion sets ready", hr[0], 1);
    chk("R5 can_commit", can_commit, 1);
    @(negedge clk); active = 2'b10; #1;
    chk("R5 inactive thread ignored", can_commit, 0);
    chk("R6 inactive thread not oldest", ov, 0);
    active = 2'b11;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule